// File: doc/BRIEF.md
# Width-Split Last Value Predictor

This block predicts the value a load instruction will return by remembering the last value seen for that load's program counter. It does not keep one wide value table. It keeps a small last-width table plus four narrow value tables, holding 8, 16, 33 and 64 bits per entry. The width table records which width class the last value for a PC fell into. A lookup reads that class first. In the next cycle it reads only the one value table that serves the class. The classes for the constants zero and one need no value table at all. The result is zero-extended to 64 bits.

The update port takes a PC and the 64 bits that the load actually returned. It measures the width of the value, which is the 1-based position of its highest set bit. It stores the class code in the width table and writes the value into the single matching narrow table. No table carries a tag, so PCs that share an index share the entry. Each table's entry count is set through its own index-width parameter. The defaults keep the 4:2:8:1:32 entry ratio across the 8-, 16-, 33- and 64-bit tables and the width table.

Top module: `wp_lvp`

## Requirements
- R1: A synchronous reset sets every width-table entry to class 0. A lookup at any PC after reset predicts class 0 with value 0, and no value-table read enable rises.
- R2: An update classifies its value with these class codes: 0 for the value 0, 1 for the value 1, 2 for widths 2..8, 3 for widths 9..16, 4 for widths 17..33 and 5 for widths 34..64. A later lookup at that PC reports the code on `pred_class`.
- R3: For codes 2 to 4, a lookup after an update returns the stored low bits zero-extended to 64 bits. For code 5 it returns all 64 bits.
- R4: For codes 0 and 1 the prediction is the constant 0 or 1, and no value-table read enable rises.
- R5: `tbl_rd_en` has at most one bit set. Bit 0 is the 8-bit table, bit 1 the 16-bit table, bit 2 the 33-bit table and bit 3 the 64-bit table. The bit that is set belongs to the class read from the width table, and it is high in the cycle after the request.
- R6: `pred_valid` pulses for one cycle two cycles after each accepted `lk_req`. It never pulses without a request. Requests on consecutive cycles each produce their own result, in order.
- R7: An update writes only the value table of its own class. Entries of the other tables keep their contents.
- R8: Tables are tagless. The width table is indexed by `pc[2 +: WT_IDX_W]` and each value table by `pc[2 +: its index width]`. Two PCs that agree in those bits share the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC of the load to predict |
| upd_req | input | 1 | Update request |
| upd_pc | input | PC_W | PC of the completed load |
| upd_value | input | 64 | Value the load returned |
| pred_valid | output | 1 | Prediction valid pulse |
| pred_class | output | 3 | Predicted width class code |
| pred_value | output | 64 | Predicted value, zero-extended |
| tbl_rd_en | output | 4 | Per-value-table read enables |

## Verification
A request driven before clock edge E1 registers the width-table read at E1. The read enables are then visible until E2, so the bench samples `tbl_rd_en` at the falling edge between E1 and E2, and it also confirms there that `pred_valid` is still low. The prediction registers at E2 and is read by a monitor at the falling edge after E2. That monitor pops the expected class and value that the driver queued at issue time, so back-to-back requests are matched in order. An update registers at one edge and is only looked up from the next falling edge onward, so the bench never relies on a write and a read of the same entry landing on one edge.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int DATA_W  = 64;
    localparam int NUM_TBL = 4;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_ONE  = 3'd1,
        CLS_B8   = 3'd2,
        CLS_B16  = 3'd3,
        CLS_B33  = 3'd4,
        CLS_B64  = 3'd5
    } wclass_e;

    // Stored bits per entry of value table i (i = 0 serves class code 2).
    function automatic int tbl_bits(input int i);
        case (i)
            0:       return 8;
            1:       return 16;
            2:       return 33;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/wp_width_class.sv
module wp_width_class
    import wp_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    output wclass_e           cls
);
    always_comb begin
        if (value == '0)                         cls = CLS_ZERO;
        else if (value == DATA_W'(1))            cls = CLS_ONE;
        else if (value[DATA_W-1:8]  == '0)       cls = CLS_B8;
        else if (value[DATA_W-1:16] == '0)       cls = CLS_B16;
        else if (value[DATA_W-1:33] == '0)       cls = CLS_B33;
        else                                     cls = CLS_B64;
    end
endmodule

// File: rtl/wp_table.sv
module wp_table #(
    parameter int DW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            rd;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mem[wr_idx] = wr_data;
        if (rd_en) st_d.rd = st_q.mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/wp_lvp.sv
module wp_lvp
    import wp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int WT_IDX_W   = 7,
    parameter int V8_IDX_W   = 4,
    parameter int V16_IDX_W  = 3,
    parameter int V33_IDX_W  = 5,
    parameter int V64_IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic              upd_req,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [63:0]       upd_value,
    output logic              pred_valid,
    output logic [2:0]        pred_class,
    output logic [63:0]       pred_value,
    output logic [3:0]        tbl_rd_en
);
    localparam int CLS_W = $bits(wclass_e);

    typedef struct packed {
        logic            s1_vld;
        logic [PC_W-1:0] s1_pc;
        logic            s2_vld;
        wclass_e         s2_cls;
    } pipe_t;

    pipe_t   pipe_d, pipe_q;
    wclass_e upd_cls;
    wclass_e wt_cls;
    logic [CLS_W-1:0] wt_rd_raw;
    logic [NUM_TBL-1:0][DATA_W-1:0] tbl_rd;
    logic [NUM_TBL-1:0] rd_en_vec;

    wp_width_class u_classify (
        .value (upd_value),
        .cls   (upd_cls)
    );

    wp_table #(.DW(CLS_W), .IW(WT_IDX_W)) u_width_tbl (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (lk_req),
        .rd_idx  (lk_pc[ALIGN_BITS +: WT_IDX_W]),
        .wr_en   (upd_req),
        .wr_idx  (upd_pc[ALIGN_BITS +: WT_IDX_W]),
        .wr_data (upd_cls),
        .rd_data (wt_rd_raw)
    );
    assign wt_cls = wclass_e'(wt_rd_raw);

    for (genvar g = 0; g < NUM_TBL; g++) begin : g_val
        localparam int DW = tbl_bits(g);
        localparam int IW = (g == 0) ? V8_IDX_W  :
                            (g == 1) ? V16_IDX_W :
                            (g == 2) ? V33_IDX_W : V64_IDX_W;
        localparam logic [CLS_W-1:0] CODE = CLS_W'(g + 2);
        logic [DW-1:0] raw;

        assign rd_en_vec[g] = pipe_q.s1_vld && (wt_cls == wclass_e'(CODE));

        wp_table #(.DW(DW), .IW(IW)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (rd_en_vec[g]),
            .rd_idx  (pipe_q.s1_pc[ALIGN_BITS +: IW]),
            .wr_en   (upd_req && (upd_cls == wclass_e'(CODE))),
            .wr_idx  (upd_pc[ALIGN_BITS +: IW]),
            .wr_data (upd_value[DW-1:0]),
            .rd_data (raw)
        );
        assign tbl_rd[g] = DATA_W'(raw);
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_vld = lk_req;
        if (lk_req) pipe_d.s1_pc = lk_pc;
        pipe_d.s2_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) pipe_d.s2_cls = wt_cls;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    always_comb begin
        case (pipe_q.s2_cls)
            CLS_ONE: pred_value = DATA_W'(1);
            CLS_B8:  pred_value = tbl_rd[0];
            CLS_B16: pred_value = tbl_rd[1];
            CLS_B33: pred_value = tbl_rd[2];
            CLS_B64: pred_value = tbl_rd[3];
            default: pred_value = '0;
        endcase
    end

    assign pred_valid = pipe_q.s2_vld;
    assign pred_class = pipe_q.s2_cls;
    assign tbl_rd_en  = rd_en_vec;
endmodule

// File: rtl/wp_lvp_chk.sv
module wp_lvp_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_req,
    input logic        pred_valid,
    input logic [2:0]  pred_class,
    input logic [63:0] pred_value,
    input logic [3:0]  tbl_rd_en
);
    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> pred_class <= 3'd5);                                   // R2
    AST_NARROW_EXT: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && pred_class == 3'd2) |-> pred_value[63:8] == '0);       // R3
    AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && pred_class == 3'd0) |-> pred_value == 64'd0);          // R4
    AST_CONST_ONE: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && pred_class == 3'd1) |-> pred_value == 64'd1);          // R4
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tbl_rd_en));                                                 // R5
    AST_READ_TO_WIDE: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_en != 4'd0) |=> (pred_valid && pred_class >= 3'd2));          // R5
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> ##2 pred_valid);                                           // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> $past(lk_req, 2));                                     // R6
endmodule

bind wp_lvp wp_lvp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_req     (lk_req),
    .pred_valid (pred_valid),
    .pred_class (pred_class),
    .pred_value (pred_value),
    .tbl_rd_en  (tbl_rd_en)
);

// File: tb/tb_wp_lvp.sv
`timescale 1ns/1ps
module tb_wp_lvp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        upd_req = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [63:0] upd_value = '0;
    logic        pred_valid;
    logic [2:0]  pred_class;
    logic [63:0] pred_value;
    logic [3:0]  tbl_rd_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0]  cls;
        logic [63:0] val;
        string       rq;
    } exp_t;
    exp_t sb[$];
    exp_t got;

    always #2 clk = ~clk;

    wp_lvp dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_pc(lk_pc),
        .upd_req(upd_req), .upd_pc(upd_pc), .upd_value(upd_value),
        .pred_valid(pred_valid), .pred_class(pred_class),
        .pred_value(pred_value), .tbl_rd_en(tbl_rd_en)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Monitor: every valid prediction is matched against the queue head.
    always @(negedge clk) begin
        if (!rst && pred_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R6 unrequested prediction actual 1 expected 0");
            end else begin
                got = sb.pop_front();
                if (pred_class !== got.cls || pred_value !== got.val) begin
                    errors++;
                    $display("FAIL %s class/value actual %0d/%h expected %0d/%h",
                             got.rq, pred_class, pred_value, got.cls, got.val);
                end
            end
        end
    end

    function automatic logic [3:0] en_of(input logic [2:0] c);
        return (c >= 3'd2) ? 4'(1 << (c - 3'd2)) : 4'd0;   // R5 bit order
    endfunction

    task automatic update(input logic [31:0] pc, input logic [63:0] v);
        @(negedge clk);
        upd_req = 1'b1; upd_pc = pc; upd_value = v;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] pc, input logic [2:0] c,
                          input logic [63:0] v, input string rq);
        exp_t e;
        e.cls = c; e.val = v; e.rq = rq;
        @(negedge clk);
        sb.push_back(e);
        lk_req = 1'b1; lk_pc = pc;
        @(negedge clk);
        lk_req = 1'b0;
        check(tbl_rd_en === en_of(c), rq, "tbl_rd_en (R5)",
              64'(tbl_rd_en), 64'(en_of(c)));
        check(pred_valid === 1'b0, "R6", "early valid", 64'(pred_valid), 64'd0);
        @(negedge clk);   // monitor compares here
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pred_valid === 1'b0, "R1", "valid after reset", 64'(pred_valid), 64'd0);
        check(tbl_rd_en === 4'd0, "R1", "enables after reset", 64'(tbl_rd_en), 64'd0);
        lookup(32'h10,  3'd0, 64'd0, "R1");
        lookup(32'h1FC, 3'd0, 64'd0, "R1");

        // R4 constants
        update(32'h04, 64'hAB);
        update(32'h04, 64'h0);
        lookup(32'h04, 3'd0, 64'd0, "R4");
        update(32'h08, 64'h1);
        lookup(32'h08, 3'd1, 64'd1, "R4");

        // R2/R3 class boundaries
        update(32'h0C, 64'h2);
        update(32'h10, 64'hFF);
        update(32'h14, 64'h100);
        update(32'h18, 64'hFFFF);
        update(32'h1C, 64'h1_0000);
        update(32'h20, 64'h1_FFFF_FFFF);
        update(32'h24, 64'h2_0000_0000);
        update(32'h28, 64'hFFFF_FFFF_FFFF_FFFF);
        lookup(32'h0C, 3'd2, 64'h2, "R2");
        lookup(32'h10, 3'd2, 64'hFF, "R3");
        lookup(32'h14, 3'd3, 64'h100, "R2");
        lookup(32'h18, 3'd3, 64'hFFFF, "R3");
        lookup(32'h1C, 3'd4, 64'h1_0000, "R2");
        lookup(32'h20, 3'd4, 64'h1_FFFF_FFFF, "R3");
        lookup(32'h24, 3'd5, 64'h2_0000_0000, "R2");
        lookup(32'h28, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R3");

        // R7: 0x40 and 0x60 share 16-bit index 0, distinct width entries
        update(32'h40, 64'h9999);
        update(32'h60, 64'h55);
        lookup(32'h40, 3'd3, 64'h9999, "R7");
        lookup(32'h60, 3'd2, 64'h55, "R7");
        update(32'h40, 64'h7);
        lookup(32'h40, 3'd2, 64'h7, "R7");

        // R8: 0x260 aliases 0x60 in width and 8-bit tables
        lookup(32'h260, 3'd2, 64'h55, "R8");
        update(32'h260, 64'hC3);
        lookup(32'h60, 3'd2, 64'hC3, "R8");

        // R6: back-to-back requests
        begin
            exp_t e;
            @(negedge clk);
            e.rq = "R6"; e.cls = 3'd5; e.val = 64'h2_0000_0000; sb.push_back(e);
            lk_req = 1'b1; lk_pc = 32'h24;
            @(negedge clk);
            e.cls = 3'd1; e.val = 64'd1; sb.push_back(e);
            lk_pc = 32'h08;
            @(negedge clk);
            e.cls = 3'd4; e.val = 64'h1_0000; sb.push_back(e);
            lk_pc = 32'h1C;
            @(negedge clk);
            lk_req = 1'b0;
            repeat (4) @(negedge clk);
        end
        check(sb.size() == 0, "R6", "pending predictions", 64'(sb.size()), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule